// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among eighteen peripheral interrupt request flags on behalf of a CPU core. Each source has its own enable bit and a two-bit programmed level built from a high and a low priority bit, which gives four levels. A global enable gates every source. In every clock cycle the controller takes the pending set and picks one winner. The highest programmed level wins. Among sources on the same level, the lowest natural index wins.

A call request is issued with the winner's vector address only when the CPU says the current instruction is in its last cycle. The call is also withheld when the instruction writes an enable or priority bit, or is a return-from-interrupt. A further condition is that no interrupt of the same or a higher level is already in service. The controller keeps one in-service bit per level. A call sets the bit for the granted level. A return-from-interrupt clears the highest bit that is set.

Requests are never latched. A source that lost a poll is considered again only if its flag is still high in a later cycle. On a call, the controller pulses a clear strobe to the sources whose flag clears itself on entry to service. A separate wake indication is raised for the one source that may wake the device from power-down.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, call_o, vec_o, grant_id_o, clr_o, wake_o and insvc_o are all zero.
- R2: Source i is pending only when flag_i[i], en_i[i] and glob_en_i are all 1. With no pending source, call_o stays 0.
- R3: The level of source i is {prio_hi_i[i], prio_lo_i[i]}, with 3 the highest. The pending source with the highest level wins.
- R4: Among pending sources of equal level, the one with the lowest index wins.
- R5: The vector address for each source index, from 0 to 17, is 0003h, 0043h, 0053h, 000Bh, 0033h, 005Bh, 0013h, 003Bh, 001Bh, 0023h, 0073h, 004Bh, 002Bh, 0063h, 006Bh, 007Bh, 0083h, 008Bh. Each address equals eight times the source's slot number plus three.
- R6: A call is issued only in a cycle where last_cycle_i is 1. Outputs are registered: call_o, vec_o and grant_id_o appear in the cycle after the poll that granted.
- R7: No call is issued in a cycle where blk_write_i or reti_i is 1.
- R8: A call is issued only if the winner's level is strictly above every level whose insvc_o bit is set. A call sets insvc_o bit [winner level].
- R9: A request that is blocked is not remembered. If its flag is low when the block lifts, no call follows.
- R10: reti_i clears the highest set bit of insvc_o on the next edge. With insvc_o at zero, reti_i has no effect.
- R11: On a call, clr_o is one-hot at the winner's index for indices 3, 8 and 16. It is also one-hot at index 0 or 6 when edge_trig_i at that index is 1. Otherwise, including index 12, clr_o stays zero.
- R12: wake_o is 1 in the cycle after flag_i[17] and en_i[17] are both 1. glob_en_i does not affect it, and no other index drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_i | input | 18 | Raw interrupt request flags |
| en_i | input | 18 | Per-source enable |
| glob_en_i | input | 1 | Global interrupt enable |
| prio_hi_i | input | 18 | High priority bit per source |
| prio_lo_i | input | 18 | Low priority bit per source |
| edge_trig_i | input | 18 | Edge-triggered mode per source (used at indices 0 and 6) |
| last_cycle_i | input | 1 | Current instruction is in its last cycle |
| blk_write_i | input | 1 | Current instruction writes an enable or priority bit |
| reti_i | input | 1 | Current instruction is a return-from-interrupt |
| call_o | output | 1 | One-cycle call request |
| vec_o | output | 16 | Vector address of the granted source |
| grant_id_o | output | 5 | Index of the granted source |
| clr_o | output | 18 | Hardware flag-clear strobe |
| insvc_o | output | 4 | In-service bit per level |
| wake_o | output | 1 | Power-down wake indication |

## Verification
The assertions check on every cycle that a call follows only a poll on a last instruction cycle with no enable write and no return-from-interrupt. They also check that the granted flag was high in that poll, that each call adds exactly one in-service level, that each return removes exactly one, and that a clear strobe comes only with a call. The bench scenarios cover what a single-cycle property cannot show. These are the level and tie ordering among competing sources, the exact vector address for each winner, and nested service followed by unwinding. The bench also covers a blocked request that is dropped and never served, the per-source auto-clear exceptions, and the wake path working with the global enable off.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC_DEF = 18;
  localparam int LVL_W    = 2;
  localparam int NLVL     = 1 << LVL_W;
  localparam int VEC_W    = 16;
  localparam int SLOT_W   = 5;

  typedef logic [LVL_W-1:0] lvl_t;

  // Slot number per natural index, index 17 first.
  localparam logic [NSRC_DEF-1:0][SLOT_W-1:0] DEF_SLOT = {
    5'd17, 5'd16, 5'd15, 5'd13, 5'd12, 5'd5, 5'd9, 5'd14, 5'd4,
    5'd3,  5'd7,  5'd2,  5'd11, 5'd6,  5'd1, 5'd10, 5'd8, 5'd0};

  // Vector address: eight bytes per slot, offset by three.
  function automatic logic [VEC_W-1:0] vec_of(input logic [SLOT_W-1:0] slot);
    return VEC_W'({slot, 3'b011});
  endfunction

  // One above the highest busy level; zero when nothing is in service.
  function automatic logic [LVL_W:0] busy_floor(input logic [NLVL-1:0] s);
    logic [LVL_W:0] f;
    f = '0;
    for (int i = 0; i < NLVL; i++)
      if (s[i]) f = (LVL_W+1)'(i + 1);
    return f;
  endfunction

  // Clear the highest set in-service bit.
  function automatic logic [NLVL-1:0] pop_top(input logic [NLVL-1:0] s);
    logic [NLVL-1:0] r;
    logic            done;
    r    = s;
    done = 1'b0;
    for (int i = NLVL-1; i >= 0; i--)
      if (r[i] && !done) begin
        r[i] = 1'b0;
        done = 1'b1;
      end
    return r;
  endfunction
endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N_SRC = 18,
  parameter int LW    = 2,
  localparam int IDW  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]         pend,
  input  logic [N_SRC-1:0][LW-1:0] lvl,
  output logic                     win_valid,
  output logic [IDW-1:0]           win_id,
  output logic [LW-1:0]            win_lvl
);
  // Scan from the top index down; ">=" lets lower indices take ties.
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_lvl   = '0;
    for (int i = N_SRC-1; i >= 0; i--) begin
      if (pend[i] && (!win_valid || lvl[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irqc_svc_stack.sv
module irqc_svc_stack #(
  parameter int LW   = 2,
  localparam int NL  = 1 << LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [NL-1:0] state,
  output logic [LW:0]   floor_lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= '0;
    else if (pop)
      state <= irqc_pkg::pop_top(state);
    else if (push)
      state[push_lvl] <= 1'b1;
  end

  assign floor_lvl = irqc_pkg::busy_floor(state);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC = irqc_pkg::NSRC_DEF,
  parameter logic [N_SRC-1:0][irqc_pkg::SLOT_W-1:0] SLOT_MAP = irqc_pkg::DEF_SLOT,
  parameter logic [N_SRC-1:0] AUTO_CLR  = N_SRC'(18'h10108),
  parameter logic [N_SRC-1:0] EDGE_SRC  = N_SRC'(18'h00041),
  parameter logic [N_SRC-1:0] WAKE_MASK = N_SRC'(18'h20000),
  localparam int IDW = $clog2(N_SRC),
  localparam int LW  = irqc_pkg::LVL_W,
  localparam int NL  = irqc_pkg::NLVL,
  localparam int VW  = irqc_pkg::VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             glob_en_i,
  input  logic [N_SRC-1:0] prio_hi_i,
  input  logic [N_SRC-1:0] prio_lo_i,
  input  logic [N_SRC-1:0] edge_trig_i,
  input  logic             last_cycle_i,
  input  logic             blk_write_i,
  input  logic             reti_i,
  output logic             call_o,
  output logic [VW-1:0]    vec_o,
  output logic [IDW-1:0]   grant_id_o,
  output logic [N_SRC-1:0] clr_o,
  output logic [NL-1:0]    insvc_o,
  output logic             wake_o
);
  // Named internal events, visible to the bound checker.
  logic [N_SRC-1:0]         pend;
  logic [N_SRC-1:0][LW-1:0] src_lvl;
  logic                     win_valid;
  logic [IDW-1:0]           win_id;
  logic [LW-1:0]            win_lvl;
  logic [LW:0]              svc_floor;
  logic                     poll_ok;
  logic                     lvl_ok;
  logic                     grant;
  logic [N_SRC-1:0]         clr_sel;

  assign pend = flag_i & en_i & {N_SRC{glob_en_i}};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_lvl[g] = {prio_hi_i[g], prio_lo_i[g]};
    assign clr_sel[g] = AUTO_CLR[g] | (EDGE_SRC[g] & edge_trig_i[g]);
  end

  irqc_arbiter #(.N_SRC(N_SRC), .LW(LW)) u_arb (
    .pend      (pend),
    .lvl       (src_lvl),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_lvl   (win_lvl)
  );

  irqc_svc_stack #(.LW(LW)) u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (grant),
    .push_lvl  (win_lvl),
    .pop       (reti_i),
    .state     (insvc_o),
    .floor_lvl (svc_floor)
  );

  assign poll_ok = last_cycle_i & ~blk_write_i & ~reti_i;
  assign lvl_ok  = ({1'b0, win_lvl} >= svc_floor);
  assign grant   = win_valid & poll_ok & lvl_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      call_o     <= 1'b0;
      vec_o      <= '0;
      grant_id_o <= '0;
      clr_o      <= '0;
      wake_o     <= 1'b0;
    end else begin
      call_o <= grant;
      wake_o <= |(flag_i & en_i & WAKE_MASK);
      if (grant) begin
        vec_o      <= irqc_pkg::vec_of(SLOT_MAP[win_id]);
        grant_id_o <= win_id;
        clr_o      <= clr_sel[win_id] ? (N_SRC'(1) << win_id) : '0;
      end else begin
        clr_o      <= '0;
      end
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N_SRC = 18,
  parameter int IDW   = 5,
  parameter int NL    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] flag_i,
  input logic             last_cycle_i,
  input logic             blk_write_i,
  input logic             reti_i,
  input logic             call_o,
  input logic [IDW-1:0]   grant_id_o,
  input logic [N_SRC-1:0] clr_o,
  input logic [NL-1:0]    insvc_o
);
  // R6: a call follows only a poll in an instruction's last cycle.
  a_r6_call_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> $past(last_cycle_i));

  // R7: writes to enable/priority bits and returns suppress the call.
  a_r7_no_call_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> (!$past(blk_write_i) && !$past(reti_i)));

  // R9: the granted flag was live in the poll that produced the call.
  a_r9_flag_was_live: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> ((($past(flag_i) >> grant_id_o) & N_SRC'(1)) != '0));

  // R8: each call adds exactly one in-service level.
  a_r8_call_pushes_one: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> ($countones(insvc_o) == $past($countones(insvc_o)) + 1));

  // R8: the in-service set grows only with a call.
  a_r8_growth_needs_call: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(insvc_o) > $past($countones(insvc_o))) |-> call_o);

  // R10: a return removes exactly one busy level.
  a_r10_reti_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && insvc_o != '0) |=> ($countones(insvc_o) == $past($countones(insvc_o)) - 1));

  // R11: clear strobes are one-hot at most and only accompany a call.
  a_r11_clr_with_call: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> (call_o && $onehot0(clr_o)));
endmodule

bind irq_prio_ctrl irqc_chk #(.N_SRC(N_SRC), .IDW(IDW), .NL(NL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flag_i       (flag_i),
  .last_cycle_i (last_cycle_i),
  .blk_write_i  (blk_write_i),
  .reti_i       (reti_i),
  .call_o       (call_o),
  .grant_id_o   (grant_id_o),
  .clr_o        (clr_o),
  .insvc_o      (insvc_o)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  localparam int N = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  flag_i, en_i, prio_hi_i, prio_lo_i, edge_trig_i;
  logic          glob_en_i, last_cycle_i, blk_write_i, reti_i;
  logic          call_o, wake_o;
  logic [15:0]   vec_o;
  logic [4:0]    grant_id_o;
  logic [N-1:0]  clr_o;
  logic [3:0]    insvc_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_i(en_i),
    .glob_en_i(glob_en_i), .prio_hi_i(prio_hi_i), .prio_lo_i(prio_lo_i),
    .edge_trig_i(edge_trig_i), .last_cycle_i(last_cycle_i),
    .blk_write_i(blk_write_i), .reti_i(reti_i), .call_o(call_o),
    .vec_o(vec_o), .grant_id_o(grant_id_o), .clr_o(clr_o),
    .insvc_o(insvc_o), .wake_o(wake_o)
  );

  // Vector address per index, written from the requirement table (R5).
  function automatic logic [15:0] exp_vec(input int id);
    case (id)
      0: return 16'h0003;  1: return 16'h0043;  2: return 16'h0053;
      3: return 16'h000B;  4: return 16'h0033;  5: return 16'h005B;
      6: return 16'h0013;  7: return 16'h003B;  8: return 16'h001B;
      9: return 16'h0023; 10: return 16'h0073; 11: return 16'h004B;
     12: return 16'h002B; 13: return 16'h0063; 14: return 16'h006B;
     15: return 16'h007B; 16: return 16'h0083; 17: return 16'h008B;
      default: return 16'h0000;
    endcase
  endfunction

  // Fields: flag[77:60] en[59:42] hi[41:24] lo[23:6] call[5] id[4:0]
  localparam logic [77:0] TBL [7] = '{
    {18'h00200, 18'h3FFFF, 18'h00000, 18'h00000, 1'b1, 5'd9},
    {18'h00410, 18'h3FFFF, 18'h00000, 18'h00000, 1'b1, 5'd4},
    {18'h00410, 18'h3FFFF, 18'h00400, 18'h00000, 1'b1, 5'd10},
    {18'h00410, 18'h3FBFF, 18'h00400, 18'h00000, 1'b1, 5'd4},
    {18'h00000, 18'h3FFFF, 18'h00000, 18'h00000, 1'b0, 5'd0},
    {18'h20004, 18'h3FFFF, 18'h20000, 18'h20004, 1'b1, 5'd17},
    {18'h10802, 18'h3FFFF, 18'h00800, 18'h10802, 1'b1, 5'd11}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    flag_i = '0; en_i = '1; prio_hi_i = '0; prio_lo_i = '0; edge_trig_i = '0;
    glob_en_i = 1'b1; last_cycle_i = 1'b1; blk_write_i = 1'b0; reti_i = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    defaults();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    defaults();
    rst_n = 1'b0;
    flag_i = '1;
    step();
    step();
    // R1: outputs quiet while in reset, even with every flag high.
    check("R1 call", 32'(call_o), 0);
    check("R1 vec", 32'(vec_o), 0);
    check("R1 insvc", 32'(insvc_o), 0);
    check("R1 clr", 32'(clr_o), 0);
    check("R1 wake", 32'(wake_o), 0);
    flag_i = '0;
    rst_n = 1'b1;
    step();
    check("R1 call after release", 32'(call_o), 0);

    // Table walk: R2, R3, R4, R5.
    for (int k = 0; k < 7; k++) begin
      do_reset();
      flag_i    = TBL[k][77:60];
      en_i      = TBL[k][59:42];
      prio_hi_i = TBL[k][41:24];
      prio_lo_i = TBL[k][23:6];
      step();
      check("R3/R4 call", 32'(call_o), 32'(TBL[k][5]));
      if (TBL[k][5]) begin
        check("R3/R4 winner", 32'(grant_id_o), 32'(TBL[k][4:0]));
        check("R5 vector", 32'(vec_o), 32'(exp_vec(int'(TBL[k][4:0]))));
      end
    end

    // R5: every index reaches its own vector when alone.
    for (int id = 0; id < N; id++) begin
      do_reset();
      flag_i = N'(1) << id;
      step();
      check("R5 vector sweep", 32'(vec_o), 32'(exp_vec(id)));
    end

    // R2: global enable and per-source enable gate the request.
    do_reset();
    flag_i = 18'h00200; glob_en_i = 1'b0;
    step();
    check("R2 global enable off", 32'(call_o), 0);
    glob_en_i = 1'b1; en_i = '0;
    step();
    check("R2 source enable off", 32'(call_o), 0);

    // R6 and R7: qualifying conditions.
    do_reset();
    flag_i = 18'h00200; last_cycle_i = 1'b0;
    step();
    check("R6 not last cycle", 32'(call_o), 0);
    last_cycle_i = 1'b1; blk_write_i = 1'b1;
    step();
    check("R7 enable write", 32'(call_o), 0);
    blk_write_i = 1'b0; reti_i = 1'b1;
    step();
    check("R7 reti", 32'(call_o), 0);
    reti_i = 1'b0;
    step();
    check("R6 granted once unblocked", 32'(call_o), 1);

    // R9: blocked request dropped before the block lifts.
    do_reset();
    flag_i = 18'h00200; last_cycle_i = 1'b0;
    step();
    flag_i = '0; last_cycle_i = 1'b1;
    step();
    check("R9 not remembered", 32'(call_o), 0);
    check("R9 insvc idle", 32'(insvc_o), 0);

    // R8: nesting by level.
    do_reset();
    flag_i = 18'h00020; prio_lo_i = 18'h00020;
    step();
    check("R8 first grant", 32'(call_o), 1);
    check("R8 insvc level1", 32'(insvc_o), 32'h2);
    step();
    check("R8 equal level blocked", 32'(call_o), 0);
    flag_i = 18'h000A8; prio_lo_i = 18'h00028; prio_hi_i = 18'h00080;
    step();
    check("R8 higher level nests", 32'(call_o), 1);
    check("R8 nested id", 32'(grant_id_o), 7);
    check("R8 insvc two levels", 32'(insvc_o), 32'h6);
    flag_i = 18'h00028;
    step();
    check("R8 lower level blocked", 32'(call_o), 0);

    // R10: returns unwind from the top.
    flag_i = '0; reti_i = 1'b1;
    step();
    check("R10 pop level2", 32'(insvc_o), 32'h2);
    step();
    check("R10 pop level1", 32'(insvc_o), 32'h0);
    step();
    check("R10 pop on empty", 32'(insvc_o), 32'h0);
    reti_i = 1'b0; flag_i = 18'h00020; prio_hi_i = '0; prio_lo_i = 18'h00020;
    step();
    check("R10 level released", 32'(call_o), 1);

    // R11: auto-clear strobes.
    do_reset(); flag_i = 18'h00100; step();
    check("R11 index8 clears", 32'(clr_o), 32'h00100);
    do_reset(); flag_i = 18'h01000; step();
    check("R11 index12 call", 32'(call_o), 1);
    check("R11 index12 no clear", 32'(clr_o), 0);
    do_reset(); flag_i = 18'h00001; step();
    check("R11 level ext no clear", 32'(clr_o), 0);
    do_reset(); flag_i = 18'h00001; edge_trig_i = 18'h00001; step();
    check("R11 edge ext clears", 32'(clr_o), 32'h00001);
    do_reset(); flag_i = 18'h00040; edge_trig_i = 18'h00040; step();
    check("R11 edge ext6 clears", 32'(clr_o), 32'h00040);
    do_reset(); flag_i = 18'h10000; step();
    check("R11 index16 clears", 32'(clr_o), 32'h10000);
    do_reset(); flag_i = 18'h00008; step();
    check("R11 index3 clears", 32'(clr_o), 32'h00008);
    do_reset(); flag_i = 18'h00002; edge_trig_i = '1; step();
    check("R11 edge ignored elsewhere", 32'(clr_o), 0);

    // R12: wake path.
    do_reset();
    glob_en_i = 1'b0; flag_i = 18'h20000; en_i = 18'h20000;
    step();
    check("R12 wake with global off", 32'(wake_o), 1);
    check("R12 no call with global off", 32'(call_o), 0);
    flag_i = 18'h10000; en_i = '1;
    step();
    check("R12 other index no wake", 32'(wake_o), 0);
    flag_i = 18'h20000; en_i = 18'h1FFFF;
    step();
    check("R12 disabled no wake", 32'(wake_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule